// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the active-low system reset of a chip from a digital supply-good flag. The flag stands in for an analog comparator that reports whether the supply is above its trip level. Reset is held for as long as the supply is reported low. It is released only after the supply has stayed good for an unbroken hold interval. That interval is counted in pulses of a one-millisecond tick input, with a default of 200 pulses.

A watchdog timeout request also forces reset. It then re-enters the same hold sequence, so a watchdog-caused reset lasts one full hold interval. It ends only if the supply is good at that time. Any dip of the supply, or any new timeout, clears the partial count, and counting starts again from zero.

The supply flag is asynchronous, so it passes through a two-flop synchronizer before use. The reset output comes straight from a state register.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, and after `rst_n` is released until a hold interval has completed, `reset_n` is 0. A value of 0 means the system is held in reset, and 1 means it is released.
- R2: After the synchronized supply flag is high, `reset_n` rises on the clock edge that samples the HOLD_TICKS-th `tick_1ms` pulse. After HOLD_TICKS-1 pulses it is still 0.
- R3: When `vcc_ok` falls while released, `reset_n` goes to 0 on the third rising clock edge after the change. Two of those edges are synchronizer stages and one is the state register.
- R4: If the supply flag drops during the hold interval, the partial count is discarded. After the supply returns, a full HOLD_TICKS pulses are needed again.
- R5: Tick pulses that arrive while the synchronized supply flag is low are not counted toward the hold interval.
- R6: A one-cycle `wdt_expire` pulse while released drives `reset_n` to 0 on the next rising edge. Reset is then released after HOLD_TICKS further tick pulses.
- R7: A `wdt_expire` pulse during the hold interval restarts the count from zero.
- R8: The counter of the hold timer never reaches HOLD_TICKS, and it is zero in the cycle after any clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1ms | input | 1 | One-cycle pulse, once per millisecond |
| vcc_ok | input | 1 | Asynchronous supply-good flag, 1 = above trip level |
| wdt_expire | input | 1 | One-cycle watchdog timeout request |
| reset_n | output | 1 | Active-low system reset |

## Verification
The assertions assume that `tick_1ms` and `wdt_expire` are single-cycle pulses, synchronous to `clk`. They also assume that the supply flag, once past the synchronizer, is a clean level. The bench drives every input on the falling clock edge, so each change is seen at exactly one known rising edge. It also holds `vcc_ok` steady for at least three cycles before any tick is expected to count. The restart cases are swept over every dip or timeout position inside the hold interval, using a small hold length. Each expected release point is computed as the tick count since the last clear.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/supply_sync.sv
module supply_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic done
);
  localparam int CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_we;

  assign done = count_en && !clear && (cnt_q == LAST);

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_we = 1'b1;
      cnt_d  = '0;
    end else if (count_en) begin
      cnt_we = 1'b1;
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < HOLD_TICKS);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_seq_pkg::*;
#(
  parameter int HOLD_TICKS  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic vcc_ok,
  input  logic wdt_expire,
  output logic reset_n
);
  logic   vcc_s;
  logic   tmr_clear;
  logic   tmr_en;
  logic   tmr_done;
  phase_e phase_q;
  phase_e phase_d;

  supply_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (vcc_ok),
    .dout (vcc_s)
  );

  assign tmr_clear = !vcc_s || wdt_expire;
  assign tmr_en    = (phase_q == PH_HOLD) && vcc_s && tick_1ms;

  hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .count_en(tmr_en),
    .done    (tmr_done)
  );

  always_comb begin
    phase_d = phase_q;
    if (tmr_clear)                            phase_d = PH_HOLD;
    else if (phase_q == PH_HOLD && tmr_done)  phase_d = PH_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_HOLD;
    else        phase_q <= phase_d;
  end

  assign reset_n = (phase_q == PH_RUN);

  assert_low_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_s |=> !reset_n);

  assert_wdt_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> !reset_n);

  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_n && !(vcc_s && tick_1ms)) |=> !reset_n);
endmodule

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n, tick_1ms, vcc_ok, wdt_expire;
  logic reset_n;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_seq #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .vcc_ok(vcc_ok),
    .wdt_expire(wdt_expire), .reset_n(reset_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    tick_1ms = 1'b1;
    step(1);
    tick_1ms = 1'b0;
    step(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wdt_pulse();
    wdt_expire = 1'b1;
    step(1);
    wdt_expire = 1'b0;
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (reset_n !== exp) begin
      failures++;
      $display("FAIL %s reset_n actual=%b expected=%b at %0t", req, reset_n, exp, $time);
    end
  endtask

  task automatic full_release(input string req);
    ticks(HOLD - 1);
    chk(req, 1'b0);
    tick();
    chk(req, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_1ms = 1'b0; vcc_ok = 1'b0; wdt_expire = 1'b0;
    step(3);
    chk("R1 in reset", 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R1 after reset", 1'b0);

    vcc_ok = 1'b1;
    step(3);
    full_release("R2 power-up hold");
    step(10);
    chk("R2 stays released", 1'b1);

    vcc_ok = 1'b0;
    step(2);
    chk("R3 two edges after drop", 1'b1);
    step(1);
    chk("R3 third edge after drop", 1'b0);

    ticks(2 * HOLD);
    chk("R5 ticks while low", 1'b0);
    vcc_ok = 1'b1;
    step(3);
    full_release("R5 full hold after low ticks");

    for (int k = 1; k < HOLD; k++) begin
      vcc_ok = 1'b0; step(3);
      vcc_ok = 1'b1; step(3);
      ticks(k);
      chk("R4 partial hold", 1'b0);
      vcc_ok = 1'b0; step(3);
      chk("R4 dip during hold", 1'b0);
      vcc_ok = 1'b1; step(3);
      full_release("R4 restart after dip");
    end

    wdt_pulse();
    chk("R6 watchdog asserts", 1'b0);
    full_release("R6 watchdog hold");

    for (int k = 1; k < HOLD; k++) begin
      wdt_pulse();
      ticks(k);
      chk("R7 partial after timeout", 1'b0);
      wdt_pulse();
      chk("R7 second timeout", 1'b0);
      full_release("R7 restart after timeout");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule